// File: doc/BRIEF.md
# Thermometer-Coded Clock Deskew Controller

This block closes the digital half of a deskew loop for a single clock tuning zone. On each strobed sample it receives a signed skew, in time units, between a reference clock edge and a leaf clock edge. It classifies the leaf as late, early or inside a dead-band. When the leaf is outside the band, it issues a two-cycle UP or DOWN pulse and moves a thermometer-coded delay word by one position. That word drives a tunable clock buffer outside this block.

The step size is the tuning range divided by one less than the word width. The dead-band half-width is one and a half steps, rounded down. Both values are fixed when the block is elaborated. A positive skew means the leaf is late, so the block removes delay. A negative skew means the leaf is early, so the block adds delay. After two in-band samples in a row, the block reports lock.

Top module: `deskew_ctrl`

## Requirements
- R1: After reset, `therm_o` holds its mid-range code (the lowest N_BITS/2 bits set, 4'b0011 for the default) and `up_o`, `down_o`, `locked_o` and `sat_o` are 0.
- R2: `up_o` and `down_o` are never 1 in the same cycle.
- R3: An accepted sample with skew > THRESH asserts `down_o` and clears the highest set bit of `therm_o`. An accepted sample with skew < -THRESH asserts `up_o` and sets the lowest clear bit. `therm_o` always stays a thermometer code and never moves by more than one bit per update. Here STEP = TUNE_RANGE/(N_BITS-1) and THRESH = (3*STEP)/2, both integer divisions, which gives 30 for the defaults.
- R4: An accepted sample with -THRESH <= skew <= THRESH asserts neither `up_o` nor `down_o` and leaves `therm_o` unchanged.
- R5: The UP or DOWN pulse starts on the clock edge that accepts the sample. It stays high for exactly two cycles. `therm_o` changes on that same edge.
- R6: A sample is accepted only when `skew_valid_i` is 1 and neither `up_o` nor `down_o` is high. Samples presented while a pulse is high are ignored.
- R7: An UP request while `therm_o` is all ones, or a DOWN request while it is all zeros, still produces the two-cycle pulse. In that case `therm_o` does not change, and `sat_o` is 1 for the two pulse cycles. At all other times `sat_o` is 0.
- R8: `locked_o` rises on the edge that accepts the second consecutive in-band sample. An accepted out-of-band sample clears it on the edge that accepts that sample.
- R9: While `skew_valid_i` is 0, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| skew_valid_i | input | 1 | Skew sample strobe |
| skew_i | input | SKEW_W | Signed skew, leaf minus reference, in time units |
| up_o | output | 1 | Add-delay pulse |
| down_o | output | 1 | Remove-delay pulse |
| therm_o | output | N_BITS | Thermometer delay word |
| locked_o | output | 1 | Loop is inside the dead-band |
| sat_o | output | 1 | Current pulse was clipped at a word limit |

## Verification
Every result is registered on the clock edge that accepts a sample, so all outputs are valid one edge after the stimulus. The pulse flags then remain high at the second edge and fall at the third. The bench drives inputs on the falling edge. For each cycle it queues the outputs a requirement-level model predicts for after the next rising edge. A monitor compares them shortly after that rising edge, so every check lands exactly on the cycle its result is due. Samples placed in the two busy cycles are checked for having no effect through the same per-cycle comparison.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [1:0] {DEC_HOLD = 2'd0, DEC_UP = 2'd1, DEC_DN = 2'd2} dec_e;
  localparam int unsigned PULSE_CYC = 2;
endpackage

// File: rtl/deskew_detect.sv
module deskew_detect
  import deskew_pkg::*;
#(
  parameter int TUNE_RANGE = 60,
  parameter int N_BITS     = 4,
  parameter int SKEW_W     = 12
) (
  input  logic signed [SKEW_W-1:0] skew_i,
  output dec_e                     dec_o
);
  localparam int STEP   = TUNE_RANGE / (N_BITS - 1);
  localparam int THRESH = (3 * STEP) / 2;

  always_comb begin
    if (int'(skew_i) > THRESH)       dec_o = DEC_DN;
    else if (int'(skew_i) < -THRESH) dec_o = DEC_UP;
    else                             dec_o = DEC_HOLD;
  end
endmodule

// File: rtl/deskew_pulse.sv
module deskew_pulse
  import deskew_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  dec_e dec_i,
  output logic accept_o,
  output logic step_up_o,
  output logic step_dn_o,
  output logic active_o,
  output logic up_o,
  output logic down_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic             active_q;
  logic             dir_up_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign accept_o  = valid_i && !active_q;
  assign start     = accept_o && (dec_i != DEC_HOLD);
  assign step_up_o = start && (dec_i == DEC_UP);
  assign step_dn_o = start && (dec_i == DEC_DN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dir_up_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      dir_up_q <= (dec_i == DEC_UP);
      cnt_q    <= CNT_W'(PULSE_CYC - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign up_o     = active_q && dir_up_q;
  assign down_o   = active_q && !dir_up_q;
endmodule

// File: rtl/deskew_therm.sv
module deskew_therm #(
  parameter int N_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_up_i,
  input  logic              step_dn_i,
  output logic [N_BITS-1:0] therm_o,
  output logic              clip_o
);
  localparam logic [N_BITS-1:0] MID_CODE = N_BITS'((1 << (N_BITS / 2)) - 1);

  logic [N_BITS-1:0] therm_q;
  logic              clip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      therm_q <= MID_CODE;
      clip_q  <= 1'b0;
    end else if (step_up_i) begin
      clip_q <= therm_q[N_BITS-1];
      if (!therm_q[N_BITS-1]) therm_q <= {therm_q[N_BITS-2:0], 1'b1};
    end else if (step_dn_i) begin
      clip_q <= !therm_q[0];
      if (therm_q[0]) therm_q <= {1'b0, therm_q[N_BITS-1:1]};
    end
  end

  assign therm_o = therm_q;
  assign clip_o  = clip_q;
endmodule

// File: rtl/deskew_lock.sv
module deskew_lock
  import deskew_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  dec_e dec_i,
  output logic locked_o
);
  logic [1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      locked_o <= 1'b0;
    end else if (accept_i) begin
      if (dec_i == DEC_HOLD) begin
        if (run_q != 2'd2) run_q <= run_q + 1'b1;
        locked_o <= (run_q != 2'd0);
      end else begin
        run_q    <= '0;
        locked_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import deskew_pkg::*;
#(
  parameter int TUNE_RANGE = 60,
  parameter int N_BITS     = 4,
  parameter int SKEW_W     = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     skew_valid_i,
  input  logic signed [SKEW_W-1:0] skew_i,
  output logic                     up_o,
  output logic                     down_o,
  output logic [N_BITS-1:0]        therm_o,
  output logic                     locked_o,
  output logic                     sat_o
);
  dec_e dec;
  logic accept, step_up, step_dn, active, clip;

  deskew_detect #(.TUNE_RANGE(TUNE_RANGE), .N_BITS(N_BITS), .SKEW_W(SKEW_W)) u_detect (
    .skew_i (skew_i),
    .dec_o  (dec)
  );

  deskew_pulse u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (skew_valid_i),
    .dec_i     (dec),
    .accept_o  (accept),
    .step_up_o (step_up),
    .step_dn_o (step_dn),
    .active_o  (active),
    .up_o      (up_o),
    .down_o    (down_o)
  );

  deskew_therm #(.N_BITS(N_BITS)) u_therm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_up_i (step_up),
    .step_dn_i (step_dn),
    .therm_o   (therm_o),
    .clip_o    (clip)
  );

  deskew_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .dec_i    (dec),
    .locked_o (locked_o)
  );

  assign sat_o = clip && active;
endmodule

// File: rtl/deskew_ctrl_chk.sv
module deskew_ctrl_chk #(
  parameter int TUNE_RANGE = 60,
  parameter int N_BITS     = 4,
  parameter int SKEW_W     = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     skew_valid_i,
  input logic signed [SKEW_W-1:0] skew_i,
  input logic                     up_o,
  input logic                     down_o,
  input logic [N_BITS-1:0]        therm_o,
  input logic                     locked_o,
  input logic                     sat_o
);
  localparam int STEP   = TUNE_RANGE / (N_BITS - 1);
  localparam int THRESH = (3 * STEP) / 2;

  logic taken, in_band;
  assign taken   = skew_valid_i && !up_o && !down_o;
  assign in_band = (int'(skew_i) <= THRESH) && (int'(skew_i) >= -THRESH);

  AST_UPDN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && down_o)); // R2

  AST_THERM_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm_o + 1'b1) & therm_o) == '0); // R3

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_o != $past(therm_o)) |->
      ($countones(therm_o ^ $past(therm_o)) == 1)); // R3

  AST_DEADBAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken && in_band) |=> ($stable(therm_o) && !up_o && !down_o)); // R4

  AST_UP_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o) |=> up_o ##1 !up_o); // R5

  AST_DN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(down_o) |=> down_o ##1 !down_o); // R5

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o || down_o) |=> (up_o || down_o || $stable(therm_o))); // R6

  AST_SAT_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> ((up_o || down_o) && $stable(therm_o))); // R7

  AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (!up_o && !down_o)); // R8

  AST_NO_VALID_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!skew_valid_i && !up_o && !down_o) |=> ($stable(therm_o) && $stable(locked_o))); // R9
endmodule

bind deskew_ctrl deskew_ctrl_chk #(
  .TUNE_RANGE(TUNE_RANGE), .N_BITS(N_BITS), .SKEW_W(SKEW_W)
) u_chk (.*);

// File: tb/deskew_ctrl_bench.sv
`timescale 1ns/1ps
module deskew_ctrl_bench;
  localparam int TUNE_RANGE = 60;
  localparam int N_BITS     = 4;
  localparam int SKEW_W     = 12;
  localparam int TH         = ((TUNE_RANGE / (N_BITS - 1)) * 3) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic signed [SKEW_W-1:0] skew = '0;
  logic up, dn, locked, sat;
  logic [N_BITS-1:0] therm;

  always #5 clk = ~clk;

  deskew_ctrl #(.TUNE_RANGE(TUNE_RANGE), .N_BITS(N_BITS), .SKEW_W(SKEW_W)) u_deskew_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .skew_valid_i(vld), .skew_i(skew),
    .up_o(up), .down_o(dn), .therm_o(therm), .locked_o(locked), .sat_o(sat)
  );

  typedef struct {
    logic up, dn, locked, sat;
    logic [N_BITS-1:0] therm;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // requirement-level model state
  int m_ones = N_BITS / 2, m_pcnt = 0, m_run = 0;
  bit m_act = 0, m_dirup = 0, m_sat = 0, m_lock = 0;

  function automatic logic [N_BITS-1:0] code(int ones);
    return N_BITS'((1 << ones) - 1);
  endfunction

  task automatic drive(bit v, int s, string tag);
    exp_t e;
    bit acc;
    @(negedge clk);
    vld = v; skew = SKEW_W'(s);
    acc = v && !m_act;
    if (acc && (s > TH || s < -TH)) begin
      m_dirup = (s < -TH);
      if (m_dirup) begin m_sat = (m_ones == N_BITS); if (!m_sat) m_ones++; end
      else         begin m_sat = (m_ones == 0);      if (!m_sat) m_ones--; end
      m_act = 1; m_pcnt = 1; m_run = 0; m_lock = 0;
    end else begin
      if (m_act) begin if (m_pcnt == 0) m_act = 0; else m_pcnt--; end
      if (acc) begin m_lock = (m_run >= 1); if (m_run < 2) m_run++; end
    end
    e.up = m_act && m_dirup; e.dn = m_act && !m_dirup;
    e.sat = m_sat && m_act; e.locked = m_lock; e.therm = code(m_ones); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(0, 500, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (up !== e.up || dn !== e.dn || therm !== e.therm || locked !== e.locked || sat !== e.sat) begin
          n_fail++;
          $display("FAIL %s: got up=%b dn=%b therm=%b lock=%b sat=%b exp up=%b dn=%b therm=%b lock=%b sat=%b",
                   e.tag, up, dn, therm, locked, sat, e.up, e.dn, e.therm, e.locked, e.sat);
        end
        if (up && dn) begin
          n_fail++;
          $display("FAIL R2: got up=1 dn=1 exp not both");
        end
      end
    end
  end

  initial begin : stim
    #23;
    n_chk++;
    if (therm !== 4'b0011 || up || dn || locked || sat) begin
      n_fail++;
      $display("FAIL R1: got therm=%b up=%b dn=%b lock=%b sat=%b exp 0011 0 0 0 0",
               therm, up, dn, locked, sat);
    end
    rst_n = 1'b1;
    idle(3, "R9 no valid");
    drive(1, TH + 1, "R3 R5 down start");
    drive(1, 200, "R6 busy ignore 1");
    drive(1, -200, "R6 busy ignore 2");
    drive(1, TH, "R4 band edge +");
    drive(1, -TH, "R4 R8 band edge -, lock");
    drive(1, 0, "R8 lock held");
    idle(2, "R9 idle locked");
    drive(1, -(TH + 1), "R3 R8 up clears lock");
    idle(2, "R5 up width");
    for (int i = 0; i < 3; i++) begin
      drive(1, 90, "R3 R7 down to floor");
      idle(2, "R7 down pulse");
    end
    for (int i = 0; i < 5; i++) begin
      drive(1, -90, "R3 R7 up to ceiling");
      drive(1, 0, "R6 R7 ignored in pulse");
      idle(1, "R7 up pulse");
    end
    drive(1, 5, "R4 R8 band 1");
    drive(1, -5, "R4 R8 band 2 lock");
    idle(3, "R9 end");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule